// File: doc/BRIEF.md
# Set/Clear Command Register Bank

This block is a bank of 32-bit control registers that software updates by command rather than by overwrite. Every register is cut into four byte lanes. In a written byte, the top bit holds a level, and the seven bits below it act as a mask. They name which register bits in that lane take that level. Any mix of bits can therefore be set or cleared in one bus write, with no read-modify-write and no risk of disturbing bits owned by other agents.

A simple memory-mapped port carries the traffic. It has a write enable, per-lane strobes, a shared register index, and a read enable whose data comes back one cycle later. Every register's contents also leave the block in parallel on a flat bus for downstream control logic. Bit 7 of each lane only carries the command level. It is never stored, so each register holds 28 live bits.

Top module: `cmdreg_bank`

## Requirements
- R1: While reset is asserted and just after its release, every register reads zero, `regs_out` is all zero and `rd_valid` is 0.
- R2: In a strobed lane whose byte has bit 7 = 1, each register bit whose mask bit (byte bits 0..6) is 1 becomes 1. For example, byte 0x9A on lane 0 sets bits 1, 3 and 4.
- R3: In a strobed lane whose byte has bit 7 = 0, each register bit whose mask bit is 1 becomes 0. For example, byte 0x1A on lane 0 clears bits 1, 3 and 4.
- R4: Register bits whose mask bit is 0 keep their value, including when the lane mask is all zero and bit 7 is 1. No register changes in a cycle with `wr_en` low.
- R5: A lane whose `wr_strb` bit is 0 is left untouched, whatever its data byte holds. Strobe bit k governs `wr_data[8k+7:8k]` and register bits `[8k+7:8k]`.
- R6: Bits 7, 15, 23 and 31 of every register always read as 0, on `rd_data` and on `regs_out`.
- R7: A read with `rd_en` high presents the addressed register on `rd_data` with `rd_valid` high in the next cycle. `rd_valid` is low in the cycle after a cycle without `rd_en`. A read and a write to the same register in one cycle return the contents from before the write.
- R8: Writes to the same register in consecutive cycles are each applied, in order, on top of the result of the previous one.
- R9: A write whose `addr` is not below the register count changes nothing. A read of such an address returns 0 with `rd_valid` high.
- R10: Register k appears on `regs_out[32k+31:32k]` and reflects a write from the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write command this cycle |
| wr_strb | input | 4 | Per-lane write strobe, bit k for byte k |
| wr_data | input | 32 | Four command bytes: bit 7 of each is the level, bits 6..0 the mask |
| rd_en | input | 1 | Read request this cycle |
| addr | input | ADDR_W (3) | Register index shared by read and write |
| rd_data | output | 32 | Read result, valid the cycle after `rd_en` |
| rd_valid | output | 1 | Marks `rd_data` as valid |
| regs_out | output | NUM_REGS*32 (160) | All register contents, register k at bits 32k+31..32k |

## Verification
The bench targets a zero mask paired with a level of 1: a design that keyed on the level bit alone would set or clear a whole lane there. It drives non-zero bytes on unstrobed lanes, which catches a design that ignored the strobe. It issues writes on back-to-back cycles, where a design that merged against a stale copy would lose an update. It also hits out-of-range indexes, where a design with a partial decode would alias onto a real register. A write and a read to one register in the same cycle expose a read path that returned post-write data. After every command, the bench checks the lane bit 7 positions, where stored command levels would show up as stray ones.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int SEL_W  = LANE_W - 1;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  lane_bits_t;

    // One command byte: level in the top bit, bit mask below it
    typedef struct packed {
        logic       level;
        lane_bits_t mask;
    } cmd_byte_t;

    // Read port state
    typedef struct packed {
        logic  valid;
        word_t data;
    } rd_state_t;

endpackage

// File: rtl/cmdreg_lane_merge.sv
module cmdreg_lane_merge
    import cmdreg_pkg::*;
(
    input  logic       lane_en,
    input  cmd_byte_t  cmd,
    input  lane_bits_t cur_bits,
    output lane_bits_t nxt_bits
);

    always_comb begin
        nxt_bits = cur_bits;
        if (lane_en) begin
            nxt_bits = (cur_bits & ~cmd.mask) | (cmd.mask & {SEL_W{cmd.level}});
        end
    end

endmodule

// File: rtl/cmdreg_word_next.sv
module cmdreg_word_next
    import cmdreg_pkg::*;
(
    input  logic             hit,
    input  logic [LANES-1:0] strb,
    input  word_t            cmd_word,
    input  word_t            cur_word,
    output word_t            nxt_word
);

    logic [LANES-1:0] lane_en;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        cmd_byte_t  cmd_l;
        lane_bits_t nxt_l;

        assign lane_en[l] = hit & strb[l];
        assign cmd_l      = cmd_byte_t'(cmd_word[l*LANE_W +: LANE_W]);

        cmdreg_lane_merge u_merge (
            .lane_en  (lane_en[l]),
            .cmd      (cmd_l),
            .cur_bits (cur_word[l*LANE_W +: SEL_W]),
            .nxt_bits (nxt_l)
        );

        // The level position holds no state
        assign nxt_word[l*LANE_W +: LANE_W] = {1'b0, nxt_l};
    end

endmodule

// File: rtl/cmdreg_read_port.sv
module cmdreg_read_port
    import cmdreg_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int ADDR_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [NUM_REGS*WORD_W-1:0] regs_flat,
    output word_t                      rd_data,
    output logic                       rd_valid
);

    rd_state_t state_d, state_q;
    word_t     sel_word;

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                sel_word = regs_flat[i*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = rd_en;
        if (rd_en) begin
            state_d.data = sel_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data  = state_q.data;
    assign rd_valid = state_q.valid;

endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank
    import cmdreg_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [LANES-1:0]           wr_strb,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    output logic [WORD_W-1:0]          rd_data,
    output logic                       rd_valid,
    output logic [NUM_REGS*WORD_W-1:0] regs_out
);

    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] regs;
    } bank_state_t;

    bank_state_t                     state_d, state_q;
    logic [NUM_REGS-1:0]             wr_hit;
    logic [NUM_REGS-1:0][WORD_W-1:0] next_words;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        assign wr_hit[i] = wr_en && (addr == ADDR_W'(i));

        cmdreg_word_next u_next (
            .hit      (wr_hit[i]),
            .strb     (wr_strb),
            .cmd_word (wr_data),
            .cur_word (state_q.regs[i]),
            .nxt_word (next_words[i])
        );
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            state_d.regs[i] = next_words[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign regs_out = state_q.regs;

    cmdreg_read_port #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (addr),
        .regs_flat (state_q.regs),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/cmdreg_bank_chk.sv
module cmdreg_bank_chk
    import cmdreg_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int ADDR_W   = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [LANES-1:0]           wr_strb,
    input logic [WORD_W-1:0]          wr_data,
    input logic                       rd_en,
    input logic [ADDR_W-1:0]          addr,
    input logic [WORD_W-1:0]          rd_data,
    input logic                       rd_valid,
    input logic [NUM_REGS*WORD_W-1:0] regs_out
);

    logic [ADDR_W-1:0]          last_addr_q;
    logic [WORD_W-1:0]          word_now, word_last, sel_mask, lvl_mask, hi_word;
    logic [NUM_REGS*WORD_W-1:0] hi_all;
    logic                       in_range;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_addr_q <= '0;
        else        last_addr_q <= addr;
    end

    always_comb begin
        word_now  = '0;
        word_last = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i))        word_now  = regs_out[i*WORD_W +: WORD_W];
            if (last_addr_q == ADDR_W'(i)) word_last = regs_out[i*WORD_W +: WORD_W];
        end
        in_range = (int'(addr) < NUM_REGS);
        for (int l = 0; l < LANES; l++) begin
            sel_mask[l*LANE_W +: LANE_W] = wr_strb[l] ? {1'b0, wr_data[l*LANE_W +: SEL_W]} : '0;
            lvl_mask[l*LANE_W +: LANE_W] = wr_data[l*LANE_W + SEL_W] ? sel_mask[l*LANE_W +: LANE_W] : '0;
            hi_word[l*LANE_W +: LANE_W]  = {1'b1, {SEL_W{1'b0}}};
        end
        hi_all = {NUM_REGS{hi_word}};
    end

    AST_MASKED_TAKE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && in_range |=> ((word_last & $past(sel_mask)) == $past(lvl_mask))); // R2

    AST_LEVEL_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && in_range && ((wr_data & hi_word) == '0) |=> ((word_last & $past(sel_mask)) == '0)); // R3

    AST_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && in_range |=> ((word_last & ~$past(sel_mask)) == ($past(word_now) & ~$past(sel_mask)))); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_out)); // R4

    AST_LEVEL_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_out & hi_all) == '0) && (!rd_valid || ((rd_data & hi_word) == '0))); // R6

    AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R7

    AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R7

    AST_RD_DATA_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && in_range |=> (rd_data == $past(word_now))); // R7

    AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !in_range |=> $stable(regs_out)); // R9

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !in_range |=> (rd_data == '0)); // R9

endmodule

bind cmdreg_bank cmdreg_bank_chk #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
) u_chk (.*);

// File: tb/tb_cmdreg_bank.sv
`timescale 1ns/1ps
module tb_cmdreg_bank;

    localparam int NREG = 5;
    localparam int AW   = 3;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [3:0]    s;
        logic [31:0]   d;
        logic [31:0]   exp;
    } vec_t;

    // Expected contents of the written register after each command
    localparam vec_t VECS [8] = '{
        '{3'd0, 4'b0001, 32'h0000_009A, 32'h0000_001A}, // R2 set bits 1,3,4
        '{3'd0, 4'b0001, 32'h0000_001A, 32'h0000_0000}, // R3 clear bits 1,3,4
        '{3'd0, 4'b1111, 32'hFFFF_FFFF, 32'h7F7F_7F7F}, // R2 R6
        '{3'd0, 4'b0010, 32'h0000_0500, 32'h7F7F_7A7F}, // R3 R4
        '{3'd0, 4'b0100, 32'h0003_00FF, 32'h7F7C_7A7F}, // R5 lane0 unstrobed
        '{3'd0, 4'b1000, 32'h8000_0000, 32'h7F7C_7A7F}, // R4 empty mask, level 1
        '{3'd1, 4'b1111, 32'h8182_8488, 32'h0102_0408}, // R2 R10
        '{3'd1, 4'b1001, 32'h7F00_00FF, 32'h0002_047F}  // R3 R5
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0;
    logic [3:0]          wr_strb = '0;
    logic [31:0]         wr_data = '0;
    logic                rd_en = 1'b0;
    logic [AW-1:0]       addr = '0;
    logic [31:0]         rd_data;
    logic                rd_valid;
    logic [NREG*32-1:0]  regs_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] mdl [NREG];

    always #2.5 clk = ~clk;

    cmdreg_bank #(.NUM_REGS(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_strb(wr_strb),
        .wr_data(wr_data), .rd_en(rd_en), .addr(addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .regs_out(regs_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_strb = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0; wr_data = '0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    function automatic logic [31:0] apply(input logic [31:0] old, input logic [3:0] s, input logic [31:0] d);
        logic [31:0] r = old;
        for (int l = 0; l < 4; l++) begin
            if (s[l]) begin
                logic [6:0] m = d[l*8 +: 7];
                r[l*8 +: 7] = (old[l*8 +: 7] & ~m) | (m & {7{d[l*8+7]}});
            end
        end
        return r;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        rv;
        for (int i = 0; i < NREG; i++) mdl[i] = '0;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 regs_out in reset", regs_out[31:0] | regs_out[159:128], 32'h0);
        check("R1 rd_valid in reset", {31'b0, rd_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 regs_out after reset", (|regs_out) ? 32'h1 : 32'h0, 32'h0);
        do_read(3'd4, rd, rv);
        check("R1 read after reset", rd, 32'h0);

        // Table walk
        foreach (VECS[k]) begin
            do_write(VECS[k].a, VECS[k].s, VECS[k].d);
            mdl[VECS[k].a] = VECS[k].exp;
            check("R10 regs_out slice", regs_out[VECS[k].a*32 +: 32], VECS[k].exp);
            do_read(VECS[k].a, rd, rv);
            check("R2 R3 R4 R5 read back", rd, VECS[k].exp);
            check("R7 rd_valid", {31'b0, rv}, 32'h1);
            @(negedge clk);
            check("R7 rd_valid drops", {31'b0, rd_valid}, 32'h0);
        end

        // R8 back-to-back writes to one register
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd2; wr_strb = 4'b0001; wr_data = 32'h81;
        @(negedge clk);
        wr_data = 32'h82;
        @(negedge clk);
        wr_data = 32'h01;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0; wr_data = '0;
        mdl[2] = 32'h2;
        check("R8 consecutive writes", regs_out[95:64], 32'h0000_0002);

        // R7 read and write together return old contents
        do_write(3'd3, 4'b0001, 32'h81);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 3'd3; wr_strb = 4'b0001; wr_data = 32'h82;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; wr_strb = '0; wr_data = '0;
        mdl[3] = 32'h3;
        check("R7 read sees pre-write value", rd_data, 32'h1);
        check("R7 write applied alongside read", regs_out[127:96], 32'h3);

        // R9 out-of-range index
        do_write(3'd5, 4'b1111, 32'hFFFF_FFFF);
        do_write(3'd7, 4'b1111, 32'h7F7F_7F7F);
        for (int i = 0; i < NREG; i++)
            check("R9 out-of-range write ignored", regs_out[i*32 +: 32], mdl[i]);
        do_read(3'd6, rd, rv);
        check("R9 out-of-range read data", rd, 32'h0);
        check("R9 out-of-range read valid", {31'b0, rv}, 32'h1);

        // Random commands against the lane model
        for (int n = 0; n < 150; n++) begin
            logic [AW-1:0] a = AW'($urandom_range(0, NREG-1));
            logic [3:0]    s = 4'($urandom);
            logic [31:0]   d = $urandom;
            do_write(a, s, d);
            mdl[a] = apply(mdl[a], s, d);
            for (int i = 0; i < NREG; i++)
                check("R2 R3 R4 R5 random model", regs_out[i*32 +: 32], mdl[i]);
            check("R6 level bits clear", regs_out[a*32 +: 32] & 32'h8080_8080, 32'h0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule